// File: doc/BRIEF.md
# Four-Bank VLIW Operand Register File

This block holds the general-purpose registers of one VLIW instruction group. The storage is split into four single-ported banks, X, Y, Z and W, each 128 entries of 32 bits. A free-running four-step cadence shares out the bank ports. During three read steps every bank can serve one read, so a group can collect up to twelve source operands. During the fourth step each bank accepts one result of the previous instruction.

Each read step has five request slots. Slots 0 to 3 are the ordinary VLIW slots. Slot 4 is the transcendental slot. It has no bank of its own, so it takes the port of whichever bank it names, and it ranks below the other slots. A request names a bank and a 7-bit register index. If two slots name the same bank in the same step, the lower-numbered slot gets the port, the rest get nothing, and a conflict flag is raised in that step.

The collected operands come out together, with a one-cycle valid pulse, after the third read step. Constants, literals, forwarding and swizzle decode stay outside the block.

Top module: `vorf_top`

## Requirements
- R1: After reset `phase` is 0 (read step 0), and `opnd_valid`, `conflict` and every bit of `opnd_hit` are 0.
- R2: `phase` advances once per clock in the order 0, 1, 2, 3 and returns to 0 after 3. Codes 0 to 2 are read steps and code 3 is the write step.
- R3: A request in read step p from slot s, with `rd_vld[s]`=1, bank `rd_bank[2s+1:2s]` and index `rd_addr[7s+6:7s]`, that is granted puts the addressed bank entry into lane L=5p+s of `opnd_data` (bits 32L+31:32L) and sets `opnd_hit[L]`. All fifteen lanes are presented together in the write-step cycle that follows read step 2.
- R4: `opnd_valid` is 1 for exactly the one cycle that follows read step 2, and 0 in every other cycle.
- R5: In the write step, `wb_en[b]`=1 writes `wb_data[32b+31:32b]` into bank b (X=0, Y=1, Z=2, W=3) at index `wb_addr[7b+6:7b]`. All four banks can be written in the same step, and the new value is returned by a read in the very next read step 0.
- R6: `wb_en` has no effect in read steps. A bank whose `wb_en` bit is 0 in the write step keeps its contents.
- R7: When two or more valid slots name the same bank in a read step, `conflict` is 1 during that step. Only the lowest-numbered of those slots is served. The other slots return hit 0 and data 0.
- R8: The transcendental slot (slot 4) can read any of the four banks, provided no lower-numbered slot uses that bank in the same step.
- R9: Read requests made in the write step are ignored, and `conflict` is 0 in the write step whatever the requests are.
- R10: The four banks are independent: the same index in different banks holds separate values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_vld | input | 5 | Per-slot read request valid (slot 4 is transcendental) |
| rd_bank | input | 10 | Per-slot bank select, 2 bits per slot |
| rd_addr | input | 35 | Per-slot register index, 7 bits per slot |
| wb_en | input | 4 | Per-bank write-back enable |
| wb_addr | input | 28 | Per-bank write-back index, 7 bits per bank |
| wb_data | input | 128 | Per-bank write-back data, 32 bits per bank |
| phase | output | 2 | Current cadence step |
| conflict | output | 1 | Same-bank collision in the current read step |
| opnd_valid | output | 1 | Operand set valid pulse |
| opnd_hit | output | 15 | Per-lane served flag |
| opnd_data | output | 480 | Collected operands, 15 lanes of 32 bits |

## Verification
The bench reads with several request patterns. Spread requests, one per bank, show that routing and lane placement are correct. Reversed and mixed bank orders across the three steps catch bank/lane mix-ups and swapped index fields. Deliberate same-bank collisions, including ones that involve the transcendental slot, separate correct lowest-slot priority from wrong priority or a missing conflict flag. Read-after-write across group boundaries, together with write enables driven in read steps and masked in the write step, shows that writes land only in the write step and only in the enabled banks.

// File: rtl/vorf_pkg.sv
package vorf_pkg;
  localparam int NBANK = 4;
  localparam int BANK_W = 2;
  localparam int NRD_STEP = 3;

  typedef enum logic [1:0] {
    PH_RD0 = 2'd0,
    PH_RD1 = 2'd1,
    PH_RD2 = 2'd2,
    PH_WR  = 2'd3
  } phase_e;

  function automatic phase_e next_phase(phase_e cur);
    return (cur == PH_WR) ? PH_RD0 : phase_e'(cur + 2'd1);
  endfunction

  function automatic int lane_of(int step, int slot, int nslot);
    return step * nslot + slot;
  endfunction
endpackage

// File: rtl/vorf_phase.sv
module vorf_phase
  import vorf_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase,
  output logic   rd_active
);
  phase_e phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_RD0;
    else        phase_q <= next_phase(phase_q);
  end

  assign phase     = phase_q;
  assign rd_active = (phase_q != PH_WR);

  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_WR |=> phase_q == PH_RD0);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != PH_WR |=> phase_q == phase_e'($past(phase_q) + 2'd1));
endmodule

// File: rtl/vorf_arb.sv
module vorf_arb
  import vorf_pkg::*;
#(
  parameter int NSLOT = 5,
  parameter int AW    = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_active,
  input  logic [NSLOT-1:0]        vld,
  input  logic [NSLOT*BANK_W-1:0] bank,
  input  logic [NSLOT*AW-1:0]     addr,
  output logic [NSLOT-1:0]        grant,
  output logic [NBANK*AW-1:0]     port_addr,
  output logic                    conflict
);
  logic [NBANK-1:0]  taken;
  logic [BANK_W-1:0] b;

  always_comb begin
    taken     = '0;
    grant     = '0;
    port_addr = '0;
    conflict  = 1'b0;
    b         = '0;
    for (int s = 0; s < NSLOT; s++) begin
      b = bank[s*BANK_W +: BANK_W];
      if (rd_active && vld[s]) begin
        if (!taken[b]) begin
          taken[b]               = 1'b1;
          grant[s]               = 1'b1;
          port_addr[b*AW +: AW]  = addr[s*AW +: AW];
        end else begin
          conflict = 1'b1;
        end
      end
    end
  end

  for (genvar gb = 0; gb < NBANK; gb++) begin : g_win
    logic [NSLOT-1:0] win;
    for (genvar gs = 0; gs < NSLOT; gs++) begin : g_s
      assign win[gs] = grant[gs] && (bank[gs*BANK_W +: BANK_W] == gb);
    end
    a_r7_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(win) <= 1);
  end

  a_r7_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~vld) == '0);
endmodule

// File: rtl/vorf_bank.sv
module vorf_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  parameter int AW     = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/vorf_top.sv
module vorf_top
  import vorf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  parameter int NSLOT  = 5,
  localparam int AW    = $clog2(DEPTH),
  localparam int NLANE = NRD_STEP * NSLOT
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSLOT-1:0]        rd_vld,
  input  logic [NSLOT*BANK_W-1:0] rd_bank,
  input  logic [NSLOT*AW-1:0]     rd_addr,
  input  logic [NBANK-1:0]        wb_en,
  input  logic [NBANK*AW-1:0]     wb_addr,
  input  logic [NBANK*DATA_W-1:0] wb_data,
  output logic [1:0]              phase,
  output logic                    conflict,
  output logic                    opnd_valid,
  output logic [NLANE-1:0]        opnd_hit,
  output logic [NLANE*DATA_W-1:0] opnd_data
);
  phase_e            ph;
  logic              rd_active;
  logic [NSLOT-1:0]  grant;
  logic [NBANK*AW-1:0] arb_addr;
  logic              wr_step;
  logic [DATA_W-1:0] bank_rd [NBANK];

  vorf_phase u_phase (
    .clk(clk), .rst_n(rst_n), .phase(ph), .rd_active(rd_active)
  );

  vorf_arb #(.NSLOT(NSLOT), .AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_n), .rd_active(rd_active),
    .vld(rd_vld), .bank(rd_bank), .addr(rd_addr),
    .grant(grant), .port_addr(arb_addr), .conflict(conflict)
  );

  assign wr_step = (ph == PH_WR);

  for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
    logic          bank_we;
    logic [AW-1:0] bank_addr;
    assign bank_we   = wr_step && wb_en[gb];
    assign bank_addr = wr_step ? wb_addr[gb*AW +: AW] : arb_addr[gb*AW +: AW];
    vorf_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_bank (
      .clk(clk), .we(bank_we), .addr(bank_addr),
      .wdata(wb_data[gb*DATA_W +: DATA_W]), .rdata(bank_rd[gb])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_valid <= 1'b0;
      opnd_hit   <= '0;
      opnd_data  <= '0;
    end else begin
      opnd_valid <= (ph == PH_RD2);
      if (rd_active) begin
        for (int s = 0; s < NSLOT; s++) begin
          opnd_hit[lane_of(int'(ph), s, NSLOT)] <= grant[s];
          opnd_data[lane_of(int'(ph), s, NSLOT)*DATA_W +: DATA_W] <=
            grant[s] ? bank_rd[rd_bank[s*BANK_W +: BANK_W]] : '0;
        end
      end
    end
  end

  assign phase = ph;

  a_r4_valid_after_rd2: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_valid |-> $past(ph) == PH_RD2);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    opnd_valid |=> !opnd_valid);
  a_r9_no_conflict_wr: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> ph != PH_WR);
  a_r9_no_grant_wr: assert property (@(posedge clk) disable iff (!rst_n)
    ph == PH_WR |-> grant == '0);
endmodule

// File: tb/vorf_top_tb.sv
module vorf_top_tb;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    rd_vld = '0;
  logic [9:0]    rd_bank = '0;
  logic [34:0]   rd_addr = '0;
  logic [3:0]    wb_en = '0;
  logic [27:0]   wb_addr = '0;
  logic [127:0]  wb_data = '0;
  logic [1:0]    phase;
  logic          conflict, opnd_valid;
  logic [14:0]   opnd_hit;
  logic [479:0]  opnd_data;

  int checks = 0;
  int fails = 0;
  logic [31:0] model [4][128];
  int qv [3][5];
  int qb [3][5];
  int qa [3][5];

  always #5 clk = ~clk;

  vorf_top u_dut (
    .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .rd_bank(rd_bank),
    .rd_addr(rd_addr), .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
    .phase(phase), .conflict(conflict), .opnd_valid(opnd_valid),
    .opnd_hit(opnd_hit), .opnd_data(opnd_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic goto_phase(int p);
    while (phase != 2'(p)) @(negedge clk);
  endtask

  task automatic clear_req();
    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 5; s++) begin qv[p][s] = 0; qb[p][s] = 0; qa[p][s] = 0; end
  endtask

  task automatic write_banks(logic [3:0] en, int addr, logic [31:0] base);
    goto_phase(3);
    wb_en = en;
    for (int b = 0; b < 4; b++) begin
      wb_addr[b*7 +: 7]  = 7'(addr);
      wb_data[b*32 +: 32] = base + 32'(b);
      if (en[b]) model[b][addr] = base + 32'(b);
    end
    @(negedge clk);
    wb_en = '0;
  endtask

  task automatic run_group(string tag);
    logic [3:0]  used;
    logic [14:0] ehit;
    logic [31:0] edat [15];
    logic        econf;
    goto_phase(0);
    for (int p = 0; p < 3; p++) begin
      used = '0; econf = 1'b0;
      for (int s = 0; s < 5; s++) begin
        rd_vld[s]         = (qv[p][s] != 0);
        rd_bank[s*2 +: 2] = 2'(qb[p][s]);
        rd_addr[s*7 +: 7] = 7'(qa[p][s]);
        ehit[p*5+s] = 1'b0; edat[p*5+s] = '0;
        if (qv[p][s] != 0) begin
          if (used[qb[p][s]]) econf = 1'b1;
          else begin
            used[qb[p][s]] = 1'b1;
            ehit[p*5+s] = 1'b1;
            edat[p*5+s] = model[qb[p][s]][qa[p][s]];
          end
        end
      end
      #1;
      check({tag, " R7 conflict"}, 32'(conflict), 32'(econf));
      @(negedge clk);
    end
    rd_vld = '0;
    #1;
    check({tag, " R4 valid"}, 32'(opnd_valid), 32'd1);
    check({tag, " R3 hits"}, 32'(opnd_hit), 32'(ehit));
    for (int l = 0; l < 15; l++)
      check({tag, " R3 lane data"}, opnd_data[l*32 +: 32], edat[l]);
  endtask

  // R1 reset state, R2 cadence
  task automatic t_reset_and_cadence();
    check("R1 phase", 32'(phase), 32'd0);
    check("R1 valid", 32'(opnd_valid), 32'd0);
    check("R1 conflict", 32'(conflict), 32'd0);
    check("R1 hit", 32'(opnd_hit), 32'd0);
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk);
      check("R2 phase order", 32'(phase), 32'(i % 4));
      check("R4 valid only after step2", 32'(opnd_valid), 32'(i % 4 == 3));
    end
  endtask

  // R5 multi-bank write, R10 independent banks
  task automatic t_fill();
    write_banks(4'hF, 5,   32'hA000_0050);
    write_banks(4'hF, 100, 32'hB000_1000);
    write_banks(4'hF, 127, 32'hC000_7F00);
    write_banks(4'hF, 0,   32'hD000_0000);
  endtask

  // R3 R10 spread reads, one slot per bank
  task automatic t_spread();
    clear_req();
    for (int s = 0; s < 4; s++) begin
      qv[0][s] = 1; qb[0][s] = s;     qa[0][s] = 5;
      qv[1][s] = 1; qb[1][s] = 3 - s; qa[1][s] = 100;
      qv[2][s] = 1; qb[2][s] = (s + 2) % 4; qa[2][s] = (s < 2) ? 127 : 0;
    end
    run_group("spread R10");
  endtask

  // R7 R8 collisions and transcendental slot
  task automatic t_conflict();
    clear_req();
    qv[0][0] = 1; qb[0][0] = 1; qa[0][0] = 5;
    qv[0][2] = 1; qb[0][2] = 1; qa[0][2] = 100;
    qv[0][4] = 1; qb[0][4] = 1; qa[0][4] = 127;
    qv[1][0] = 1; qb[1][0] = 0; qa[1][0] = 100;
    qv[1][4] = 1; qb[1][4] = 2; qa[1][4] = 127;
    qv[2][3] = 1; qb[2][3] = 3; qa[2][3] = 0;
    qv[2][4] = 1; qb[2][4] = 3; qa[2][4] = 5;
    qv[2][1] = 1; qb[2][1] = 1; qa[2][1] = 0;
    run_group("collide R8");
  endtask

  // R5 read-after-write into next step 0
  task automatic t_raw();
    write_banks(4'b0100, 5, 32'h1234_0000);
    clear_req();
    qv[0][4] = 1; qb[0][4] = 2; qa[0][4] = 5;
    qv[0][0] = 1; qb[0][0] = 0; qa[0][0] = 5;
    run_group("raw R5");
  endtask

  // R6 wb_en in read steps and masked banks; R9 requests in write step
  task automatic t_ignored();
    goto_phase(0);
    wb_en = 4'hF;
    for (int b = 0; b < 4; b++) begin
      wb_addr[b*7 +: 7] = 7'd0; wb_data[b*32 +: 32] = 32'hDEAD_BEEF;
    end
    repeat (3) @(negedge clk);
    wb_en = '0;
    write_banks(4'b0001, 100, 32'h5555_0000);
    goto_phase(3);
    rd_vld = 5'h1F; rd_bank = '0; rd_addr = '0;
    #1;
    check("R9 conflict in write step", 32'(conflict), 32'd0);
    @(negedge clk);
    rd_vld = '0;
    clear_req();
    for (int s = 0; s < 4; s++) begin
      qv[0][s] = 1; qb[0][s] = s; qa[0][s] = 0;
      qv[1][s] = 1; qb[1][s] = s; qa[1][s] = 100;
    end
    run_group("ignored R6");
  endtask

  initial begin
    for (int b = 0; b < 4; b++)
      for (int a = 0; a < 128; a++) model[b][a] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset_and_cadence();
    t_fill();
    t_spread();
    t_conflict();
    t_raw();
    t_ignored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule